// File: doc/BRIEF.md
# Modulo Alarm Timer

A 16-bit up-counter peripheral meant for alarm and wakeup duties. Software programs it through a plain register write strobe with a combinational read path. The count is driven by one of two sources: every system clock cycle, or a single-cycle slow tick-enable input (a 32 kHz rate, already in the system clock domain). A power-of-two prescaler sits after the source select.

The counter runs from a programmable start value up to a programmable limit. On the step after it reaches the limit it reloads the start value, and that transition raises a sticky overflow flag. When the interrupt enable is set, the flag drives a level interrupt. Software clears the flag by writing the control register with the flag bit at zero. Any write to the count register restarts the count from the start value.

To set up an alarm of N ticks, software sets the start value to 0, writes the limit as N-1, restarts the count and then enables the source.

The register port is a control interface, not a data stream. It has no back-pressure: a write takes effect at the clock edge where `bus_wen` is high, and `bus_rdata` follows `bus_addr` in the same cycle.

Top module: `modulo_alarm_timer`

## Requirements
- R1: After reset, the count, start and control registers read 0, the limit register reads 0xFFFF, and `irq` is 0.
- R2: The registers sit at these offsets: control at 0x00, count at 0x04, limit at 0x08, start at 0x4C. Control holds the prescale code in bits [2:0], the source select in bits [4:3], the interrupt enable in bit 6 and the overflow flag in bit 7. All other control bits read 0. Limit and start keep 16 bits.
- R3: The source select works as follows. Code 0 and code 3 stop the counter. Code 1 gives one source pulse per system clock. Code 2 gives one source pulse per cycle in which `slow_tick` is 1.
- R4: With prescale code P, the counter advances once every 2^P source pulses.
- R5: When a step occurs with the count equal to the limit, the count loads the start value instead of incrementing.
- R6: The overflow flag is set only on the limit-to-start transition, and it stays set until software clears it.
- R7: A write of any data to the count register loads the start value into the count and restarts the prescaler.
- R8: A control write with bit 7 at 0 clears the flag. A control write with bit 7 at 1 leaves the flag unchanged.
- R9: If a wrap and a flag-clearing control write fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly while both the flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Single-cycle enable from the fixed slow time base |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq | output | 1 | Level overflow interrupt |

## Verification
The counting function is driven in several ways. Free-running system-clock stepping checks the basic increment rate. Sparse `slow_tick` pulses, spaced several cycles apart, separate "count per tick" from "count per clock". Prescale codes 1, 2 and 3 are sampled mid-period, which catches an off-by-one divider. A short start-to-limit window is watched cycle by cycle, which separates a reload at the limit from a reload one step late and shows that the flag rises only at the wrap. A clearing write placed exactly on the wrap edge tells a set-wins flag from a clear-wins flag. Runs with the interrupt enable on and off tell the level interrupt apart from the raw flag.

// File: rtl/mat_pkg.sv
package mat_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_TICK = 2'd2,
    SRC_RSVD = 2'd3
  } src_sel_e;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_COUNT = 8'h04;
  localparam logic [7:0] OFF_LIMIT = 8'h08;
  localparam logic [7:0] OFF_START = 8'h4C;
endpackage

// File: rtl/mat_prescaler.sv
module mat_prescaler
  import mat_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  src_sel_e        src,
  input  logic [PS_W-1:0] ps,
  input  logic            slow_tick,
  input  logic            restart,
  output logic            step
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam logic [DIV_W-1:0] ONES = '1;
  localparam logic [PS_W-1:0] PS_MAX = PS_W'(DIV_W);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic             active;
  logic             pulse;
  logic             terminal;

  assign active   = (src == SRC_SYS) || (src == SRC_TICK);
  assign pulse    = (src == SRC_SYS) || ((src == SRC_TICK) && slow_tick);
  assign lim      = ONES >> (PS_MAX - ps);
  assign terminal = (div_q >= lim);
  assign step     = active && !restart && pulse && terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!active || restart) begin
      div_q <= '0;
    end else if (pulse) begin
      div_q <= terminal ? '0 : div_q + 1'b1;
    end
  end

  AST_NO_STEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((src == SRC_OFF) || (src == SRC_RSVD)) |-> !step); // R3
  AST_TICK_GATES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((src == SRC_TICK) && !slow_tick) |-> !step); // R3
endmodule

// File: rtl/mat_counter.sv
module mat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] limit_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic at_limit;

  assign at_limit = (cnt == limit_val);
  assign wrap     = step && at_limit && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= start_val;
    end else if (step) begin
      cnt <= at_limit ? start_val : cnt + 1'b1;
    end
  end

  AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(start_val))); // R7
  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == $past(start_val))); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt)); // R3
endmodule

// File: rtl/mat_regs.sv
module mat_regs
  import mat_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output logic [DATA_W-1:0] rdata,
  output logic [PS_W-1:0]   ps,
  output src_sel_e          src,
  output logic              ie,
  output logic              flag,
  output logic [CNT_W-1:0]  limit_val,
  output logic [CNT_W-1:0]  start_val,
  output logic              cnt_wr
);
  localparam int SRC_LSB  = PS_W;
  localparam int IE_BIT   = PS_W + 3;
  localparam int FLAG_BIT = PS_W + 4;

  logic ctrl_wr;
  logic limit_wr;
  logic start_wr;
  logic unused_wdata;

  assign ctrl_wr  = wen && (addr == ADDR_W'(OFF_CTRL));
  assign cnt_wr   = wen && (addr == ADDR_W'(OFF_COUNT));
  assign limit_wr = wen && (addr == ADDR_W'(OFF_LIMIT));
  assign start_wr = wen && (addr == ADDR_W'(OFF_START));
  assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps  <= '0;
      src <= SRC_OFF;
      ie  <= 1'b0;
    end else if (ctrl_wr) begin
      ps  <= wdata[PS_W-1:0];
      src <= src_sel_e'(wdata[SRC_LSB+1:SRC_LSB]);
      ie  <= wdata[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (wrap) begin
      flag <= 1'b1;
    end else if (ctrl_wr && !wdata[FLAG_BIT]) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_val <= '1;
      start_val <= '0;
    end else begin
      if (limit_wr) limit_val <= wdata[CNT_W-1:0];
      if (start_wr) start_val <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_CTRL)) begin
      rdata = DATA_W'({flag, ie, 1'b0, src, ps});
    end else if (addr == ADDR_W'(OFF_COUNT)) begin
      rdata = DATA_W'(cnt);
    end else if (addr == ADDR_W'(OFF_LIMIT)) begin
      rdata = DATA_W'(limit_val);
    end else if (addr == ADDR_W'(OFF_START)) begin
      rdata = DATA_W'(start_val);
    end
  end

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag); // R9
  AST_FLAG_RISES_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wrap)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ctrl_wr) |=> flag); // R8
endmodule

// File: rtl/modulo_alarm_timer.sv
module modulo_alarm_timer
  import mat_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [PS_W-1:0]  ps;
  src_sel_e         src;
  logic             ie;
  logic             flag;
  logic [CNT_W-1:0] limit_val;
  logic [CNT_W-1:0] start_val;
  logic [CNT_W-1:0] cnt;
  logic             cnt_wr;
  logic             step;
  logic             wrap;

  mat_regs #(
    .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt), .wrap(wrap), .rdata(bus_rdata),
    .ps(ps), .src(src), .ie(ie), .flag(flag),
    .limit_val(limit_val), .start_val(start_val), .cnt_wr(cnt_wr)
  );

  mat_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .src(src), .ps(ps),
    .slow_tick(slow_tick), .restart(cnt_wr), .step(step)
  );

  mat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(cnt_wr),
    .start_val(start_val), .limit_val(limit_val), .cnt(cnt), .wrap(wrap)
  );

  assign irq = flag && ie;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ie && !bus_wen) |=> irq); // R10
endmodule

// File: tb/modulo_alarm_timer_tb.sv
module modulo_alarm_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modulo_alarm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_CNT  = 8'h04;
  localparam logic [7:0] A_LIM  = 8'h08;
  localparam logic [7:0] A_STA  = 8'h4C;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    rd(A_CNT, v);  check("R1 count", v, 32'h0);
    rd(A_LIM, v);  check("R1 limit", v, 32'hFFFF);
    rd(A_STA, v);  check("R1 start", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_LIM, 32'hFFFF_1234);
    wr(A_STA, 32'h0001_0055);
    wr(A_CTRL, 32'hFFFF_FF7F);
    @(negedge clk);
    rd(A_LIM, v);  check("R2 limit", v, 32'h1234);
    rd(A_STA, v);  check("R2 start", v, 32'h0055);
    rd(A_CTRL, v); check("R2 ctrl fields", v, 32'h5F);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_stopped();
    logic [31:0] v;
    wr(A_STA, 32'h0);
    wr(A_LIM, 32'hFFFF);
    wr(A_CTRL, 32'h18);
    wr(A_CNT, 32'h0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, v); check("R3 code 3 stopped", v, 32'h0);
    wr(A_CTRL, 32'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, v); check("R3 code 0 stopped", v, 32'h0);
  endtask

  task automatic t_sysclk();
    logic [31:0] v;
    wr(A_CTRL, 32'h08);
    wr(A_CNT, 32'h0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, v); check("R3 system clock rate", v, 32'd10);
    wr(A_CTRL, 32'h00);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    wr(A_CTRL, 32'h10);
    wr(A_CNT, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
    rd(A_CNT, v); check("R3 one count per tick", v, 32'd4);
    wr(A_CTRL, 32'h11);
    wr(A_CNT, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    rd(A_CNT, v); check("R4 tick divided by 2", v, 32'd2);
    wr(A_CTRL, 32'h00);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(A_CTRL, 32'h0A);
    wr(A_CNT, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, v); check("R4 div4 before period", v, 32'd0);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, v); check("R4 div4 first step", v, 32'd1);
    repeat (8) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, v); check("R4 div4 third step", v, 32'd3);
    wr(A_CTRL, 32'h0B);
    wr(A_CNT, 32'h9999);
    repeat (16) @(posedge clk);
    @(negedge clk);
    rd(A_CNT, v); check("R7 restart then R4 div8", v, 32'd2);
    wr(A_CTRL, 32'h00);
    wr(A_STA, 32'h5);
    wr(A_CNT, 32'hABCD);
    @(negedge clk);
    rd(A_CNT, v); check("R7 count write loads start", v, 32'd5);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(A_CTRL, 32'h00);
    wr(A_STA, 32'd5);
    wr(A_LIM, 32'd8);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h48);
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk); @(negedge clk);
      rd(A_CNT, v); check("R5 counting up", v, 32'(5 + k));
      rd(A_CTRL, v); check("R6 no flag before wrap", {31'b0, v[7]}, 32'h0);
      check("R10 irq low before wrap", {31'b0, irq}, 32'h0);
    end
    @(posedge clk); @(negedge clk);
    rd(A_CNT, v); check("R5 reload to start", v, 32'd5);
    rd(A_CTRL, v); check("R6 flag on wrap", v, 32'hC8);
    check("R10 irq high", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'hC0);
    @(negedge clk);
    rd(A_CTRL, v); check("R8 writing 1 keeps flag", v, 32'hC0);
    check("R10 irq held", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h40);
    @(negedge clk);
    rd(A_CTRL, v); check("R8 writing 0 clears flag", v, 32'h40);
    check("R10 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    wr(A_CTRL, 32'h00);
    wr(A_STA, 32'd0);
    wr(A_LIM, 32'd3);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h08);
    repeat (3) @(posedge clk);
    wr(A_CTRL, 32'h08);
    @(negedge clk);
    rd(A_CNT, v); check("R5 wrap to start 0", v, 32'd0);
    rd(A_CTRL, v); check("R9 set wins over clear", {31'b0, v[7]}, 32'h1);
    check("R10 irq low with enable off", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h00);
    @(negedge clk);
    rd(A_CTRL, v); check("R8 clear after stop", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_stopped();
    t_sysclk();
    t_tick();
    t_prescale();
    t_wrap();
    t_set_wins();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule